// File: doc/BRIEF.md
# Dual-Issue Memory Hazard Resolver

This block sits beside the memory stage of a two-wide in-order pipeline. Each of the two lanes, A (the older instruction) and B (the younger one), can present a load or a store in the same cycle. The block compares the two word addresses and the two operation kinds. For each lane it decides whether to hold the lane, pass store data on to a load, or discard a store that a newer one overwrites.

Stores do not go straight to the data cache. They are collected in a small store queue built from flip-flops. The queue takes up to two entries per cycle, A's entry ahead of B's. It hands out its oldest entry through a simple drain port, one entry per cycle. Every load searches this queue before the data cache is consulted, and the youngest matching entry supplies the data. Device (memory-mapped) addresses sit at or above a parameterised base. Two same-cycle stores to such an address are both kept, so that a device sees every write in program order.

Top module: `mhr_resolver`

## Requirements
- R1: After reset the store queue is empty, `dr_vld` is low, and no lane is stalled.
- R2: When lane A loads and lane B stores the same word address, `b_stall` stays high and B's store is not queued in every cycle where `a_ld_done` is low. During this hold `a_stall` stays low. B's store is queued in the cycle where `a_ld_done` is high.
- R3: When lane A stores and lane B loads the same word address, neither lane stalls for the pair. `b_fwd_hit` is high and `b_fwd_data` equals A's store data in that same cycle.
- R4: When both lanes store the same word address below `MMIO_BASE`, `a_drop` is high and only B's store enters the queue.
- R5: When both lanes store the same word address at or above `MMIO_BASE`, `a_drop` stays low. Both stores are queued and drain with A's data first, then B's.
- R6: A load hits when a queued entry has the same address. The youngest such entry supplies the data. A lane-B load prefers a same-cycle lane-A store to the same address over any queued entry. A lane-A load never sees lane B's same-cycle store.
- R7: Free space is DEPTH minus the occupancy at the start of the cycle; a drain in the same cycle does not count. If the stores that would be queued this cycle need more entries than are free, `a_stall` and `b_stall` are both high, nothing is queued, and `a_drop` is low.
- R8: `dr_vld` is high exactly when the queue holds an entry. `dr_addr` and `dr_data` show the oldest entry. A cycle with `dr_vld` and `dr_ack` high removes that one entry.
- R9: A lane whose valid input is low causes no stall, no forwarding and no queue write.
- R10: Addresses are compared over the full word address, so two stores or a store and a load one word apart never interact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_vld | input | 1 | Lane A carries a memory operation |
| a_st | input | 1 | Lane A operation is a store (0 = load) |
| a_addr | input | AW | Lane A word address |
| a_wdata | input | DW | Lane A store data |
| a_ld_done | input | 1 | Lane A load completes this cycle (hit or end of miss) |
| b_vld | input | 1 | Lane B carries a memory operation |
| b_st | input | 1 | Lane B operation is a store (0 = load) |
| b_addr | input | AW | Lane B word address |
| b_wdata | input | DW | Lane B store data |
| dr_ack | input | 1 | Downstream takes the oldest queued store |
| a_stall | output | 1 | Hold lane A this cycle |
| b_stall | output | 1 | Hold lane B this cycle |
| a_drop | output | 1 | Lane A store is discarded as overwritten |
| a_fwd_hit | output | 1 | Lane A load found its data in the store queue |
| a_fwd_data | output | DW | Data for lane A load |
| b_fwd_hit | output | 1 | Lane B load found data in the queue or in A's store |
| b_fwd_data | output | DW | Data for lane B load |
| dr_vld | output | 1 | Store queue holds at least one entry |
| dr_addr | output | AW | Word address of the oldest entry |
| dr_data | output | DW | Data of the oldest entry |

## Verification
The bench builds the block with DEPTH=4, AW=8, DW=16 and MMIO_BASE=8'hF0. Four entries let a handful of stores fill the queue. That brings both the full-queue stall (R7) and pointer wrap-around during draining within a short run. With the 8-bit address, a device address is easy to reach, so the kept double store of R5 can be followed all the way out of the drain port.

// File: rtl/mhr_pkg.sv
package mhr_pkg;

  // Relation between the two lanes' memory operations this cycle
  typedef enum logic [1:0] {
    HZ_NONE  = 2'd0,
    HZ_LD_ST = 2'd1,  // A loads, B stores same word
    HZ_ST_LD = 2'd2,  // A stores, B loads same word
    HZ_ST_ST = 2'd3   // both store same word
  } hz_kind_t;

  // Number of queue slots requested by two write enables
  function automatic logic [1:0] slots_needed(input logic wa, input logic wb);
    return {1'b0, wa} + {1'b0, wb};
  endfunction

endpackage

// File: rtl/mhr_pair.sv
module mhr_pair
  import mhr_pkg::*;
#(
  parameter int AW = 8,
  parameter logic [AW-1:0] MMIO_BASE = '1
) (
  input  logic          a_vld,
  input  logic          a_st,
  input  logic [AW-1:0] a_addr,
  input  logic          b_vld,
  input  logic          b_st,
  input  logic [AW-1:0] b_addr,
  output hz_kind_t      kind,
  output logic          dev_addr
);

  function automatic logic is_device(input logic [AW-1:0] ad);
    return ad >= MMIO_BASE;
  endfunction

  logic same_word;

  always_comb begin
    same_word = a_vld && b_vld && (a_addr == b_addr);
    kind      = HZ_NONE;
    if (same_word) begin
      unique case ({a_st, b_st})
        2'b01:   kind = HZ_LD_ST;
        2'b10:   kind = HZ_ST_LD;
        2'b11:   kind = HZ_ST_ST;
        default: kind = HZ_NONE;
      endcase
    end
    dev_addr = is_device(a_addr);
  end

endmodule

// File: rtl/mhr_sbuf.sv
module mhr_sbuf #(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 16,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_a,
  input  logic [AW-1:0] wr_a_addr,
  input  logic [DW-1:0] wr_a_data,
  input  logic          wr_b,
  input  logic [AW-1:0] wr_b_addr,
  input  logic [DW-1:0] wr_b_data,
  input  logic          pop,
  input  logic [AW-1:0] qa_addr,
  output logic          qa_hit,
  output logic [DW-1:0] qa_data,
  input  logic [AW-1:0] qb_addr,
  output logic          qb_hit,
  output logic [DW-1:0] qb_data,
  output logic [CW-1:0] occ,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data
);

  logic [AW-1:0] e_addr [DEPTH];
  logic [DW-1:0] e_data [DEPTH];
  logic [PW-1:0] head, tail;
  logic [CW-1:0] cnt;

  // index arithmetic on a ring of DEPTH slots, any depth
  function automatic logic [PW-1:0] ring_add(input logic [PW-1:0] base, input int off);
    int s;
    s = int'(base) + off;
    if (s >= DEPTH) s = s - DEPTH;
    return PW'(s);
  endfunction

  // youngest live entry matching the address wins
  function automatic logic [DW:0] lookup(input logic [AW-1:0] q);
    logic [DW:0] r;
    logic [PW-1:0] ix;
    r = '0;
    for (int k = 0; k < DEPTH; k++) begin
      ix = ring_add(head, k);
      if ((k < int'(cnt)) && (e_addr[ix] == q)) r = {1'b1, e_data[ix]};
    end
    return r;
  endfunction

  always_comb begin
    {qa_hit, qa_data} = lookup(qa_addr);
    {qb_hit, qb_data} = lookup(qb_addr);
  end

  assign occ       = cnt;
  assign head_addr = e_addr[head];
  assign head_data = e_data[head];

  logic [PW-1:0] slot_b;
  assign slot_b = wr_a ? ring_add(tail, 1) : tail;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else begin
      head <= pop ? ring_add(head, 1) : head;
      tail <= ring_add(tail, int'(wr_a) + int'(wr_b));
      cnt  <= CW'(int'(cnt) + int'(wr_a) + int'(wr_b) - int'(pop));
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (wr_a && tail == PW'(g)) begin
          e_addr[g] <= wr_a_addr;
          e_data[g] <= wr_a_data;
        end else if (wr_b && slot_b == PW'(g)) begin
          e_addr[g] <= wr_b_addr;
          e_data[g] <= wr_b_data;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/mhr_resolver.sv
module mhr_resolver
  import mhr_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter logic [AW-1:0] MMIO_BASE = 8'hF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_vld,
  input  logic          a_st,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  input  logic          a_ld_done,
  input  logic          b_vld,
  input  logic          b_st,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  input  logic          dr_ack,
  output logic          a_stall,
  output logic          b_stall,
  output logic          a_drop,
  output logic          a_fwd_hit,
  output logic [DW-1:0] a_fwd_data,
  output logic          b_fwd_hit,
  output logic [DW-1:0] b_fwd_data,
  output logic          dr_vld,
  output logic [AW-1:0] dr_addr,
  output logic [DW-1:0] dr_data
);

  localparam int CW = $clog2(DEPTH + 1);

  hz_kind_t      kind;
  logic          dev_addr;
  logic          hold_b, kill_a, full_stall;
  logic          wr_a, wr_b, pop_fire;
  logic [1:0]    need, push_n;
  logic [CW-1:0] occ;
  logic          qa_hit, qb_hit;
  logic [DW-1:0] qa_data, qb_data;

  mhr_pair #(.AW(AW), .MMIO_BASE(MMIO_BASE)) u_pair (
    .a_vld(a_vld), .a_st(a_st), .a_addr(a_addr),
    .b_vld(b_vld), .b_st(b_st), .b_addr(b_addr),
    .kind(kind), .dev_addr(dev_addr)
  );

  // hazard decisions before the capacity check
  assign hold_b = (kind == HZ_LD_ST) && !a_ld_done;
  assign kill_a = (kind == HZ_ST_ST) && !dev_addr;
  assign need   = slots_needed(a_vld && a_st && !kill_a, b_vld && b_st && !hold_b);

  // capacity: free space ignores a same-cycle drain
  assign full_stall = int'(need) > (DEPTH - int'(occ));

  assign wr_a     = a_vld && a_st && !kill_a && !full_stall;
  assign wr_b     = b_vld && b_st && !hold_b && !full_stall;
  assign push_n   = slots_needed(wr_a, wr_b);
  assign pop_fire = dr_vld && dr_ack;

  assign a_stall = full_stall;
  assign b_stall = full_stall || hold_b;
  assign a_drop  = kill_a && !full_stall;

  mhr_sbuf #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_sbuf (
    .clk(clk), .rst_n(rst_n),
    .wr_a(wr_a), .wr_a_addr(a_addr), .wr_a_data(a_wdata),
    .wr_b(wr_b), .wr_b_addr(b_addr), .wr_b_data(b_wdata),
    .pop(pop_fire),
    .qa_addr(a_addr), .qa_hit(qa_hit), .qa_data(qa_data),
    .qb_addr(b_addr), .qb_hit(qb_hit), .qb_data(qb_data),
    .occ(occ), .head_addr(dr_addr), .head_data(dr_data)
  );

  assign dr_vld = (occ != '0);

  // lane A load: queue only; lane B load: A's in-flight store first
  always_comb begin
    a_fwd_hit  = a_vld && !a_st && qa_hit;
    a_fwd_data = qa_data;
    if (kind == HZ_ST_LD) begin
      b_fwd_hit  = 1'b1;
      b_fwd_data = a_wdata;
    end else begin
      b_fwd_hit  = b_vld && !b_st && qb_hit;
      b_fwd_data = qb_data;
    end
  end

endmodule

// File: rtl/mhr_resolver_chk.sv
module mhr_resolver_chk #(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter logic [AW-1:0] MMIO_BASE = 8'hF0,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          a_vld,
  input logic          a_st,
  input logic [AW-1:0] a_addr,
  input logic [DW-1:0] a_wdata,
  input logic          a_ld_done,
  input logic          b_vld,
  input logic          b_st,
  input logic [AW-1:0] b_addr,
  input logic          a_stall,
  input logic          b_stall,
  input logic          a_drop,
  input logic          b_fwd_hit,
  input logic [DW-1:0] b_fwd_data,
  input logic [CW-1:0] occ,
  input logic [1:0]    push_n,
  input logic          pop_fire
);

  logic          live_q;
  logic [CW-1:0] occ_q;
  logic [1:0]    push_q;
  logic          pop_q;
  logic [CW+1:0] occ_expect;

  always_ff @(posedge clk) begin
    live_q <= rst_n;
    occ_q  <= occ;
    push_q <= push_n;
    pop_q  <= pop_fire;
  end

  assign occ_expect = (CW+2)'(occ_q) + (CW+2)'(push_q) - (CW+2)'(pop_q);

  // R4
  drop_only_same_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_drop |-> (a_vld && a_st && b_vld && b_st && a_addr == b_addr && a_addr < MMIO_BASE));

  // R7
  full_stall_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_stall |-> (b_stall && !a_drop));

  // R2
  load_store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_vld && !a_st && b_vld && b_st && a_addr == b_addr && !a_ld_done) |-> (b_stall && !a_stall));

  // R3
  store_load_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_vld && a_st && b_vld && !b_st && a_addr == b_addr) |-> (b_fwd_hit && b_fwd_data == a_wdata && !b_stall));

  // R8
  occupancy_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> ((CW+2)'(occ) == occ_expect));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= DEPTH);

endmodule

bind mhr_resolver mhr_resolver_chk #(
  .DEPTH(DEPTH), .AW(AW), .DW(DW), .MMIO_BASE(MMIO_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .a_vld(a_vld), .a_st(a_st), .a_addr(a_addr), .a_wdata(a_wdata), .a_ld_done(a_ld_done),
  .b_vld(b_vld), .b_st(b_st), .b_addr(b_addr),
  .a_stall(a_stall), .b_stall(b_stall), .a_drop(a_drop),
  .b_fwd_hit(b_fwd_hit), .b_fwd_data(b_fwd_data),
  .occ(occ), .push_n(push_n), .pop_fire(pop_fire)
);

// File: tb/sim_mhr_resolver.sv
module sim_mhr_resolver;

  localparam int DEPTH = 4;
  localparam int AW    = 8;
  localparam int DW    = 16;
  localparam logic [AW-1:0] DEVB = 8'hF0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_vld = 0, a_st = 0, a_ld_done = 0, b_vld = 0, b_st = 0, dr_ack = 0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic a_stall, b_stall, a_drop, a_fwd_hit, b_fwd_hit, dr_vld;
  logic [DW-1:0] a_fwd_data, b_fwd_data, dr_data;
  logic [AW-1:0] dr_addr;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  mhr_resolver #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .MMIO_BASE(DEVB)) u0 (
    .clk(clk), .rst_n(rst_n),
    .a_vld(a_vld), .a_st(a_st), .a_addr(a_addr), .a_wdata(a_wdata), .a_ld_done(a_ld_done),
    .b_vld(b_vld), .b_st(b_st), .b_addr(b_addr), .b_wdata(b_wdata), .dr_ack(dr_ack),
    .a_stall(a_stall), .b_stall(b_stall), .a_drop(a_drop),
    .a_fwd_hit(a_fwd_hit), .a_fwd_data(a_fwd_data),
    .b_fwd_hit(b_fwd_hit), .b_fwd_data(b_fwd_data),
    .dr_vld(dr_vld), .dr_addr(dr_addr), .dr_data(dr_data)
  );

  typedef struct packed {
    logic av; logic as; logic [7:0] aa; logic [15:0] ad; logic adn;
    logic bv; logic bs; logic [7:0] ba; logic [15:0] bd; logic ack;
    logic ea; logic eb; logic edrop;
    logic eah; logic [15:0] ead; logic ebh; logic [15:0] ebd;
    logic edv; logic [7:0] eda; logic [15:0] edd;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t TBL [NV] = '{
    // inputs: A(v,st,addr,data,done) B(v,st,addr,data) ack | expected
    '{1,0,8'h10,16'h0,0, 1,0,8'h11,16'h0,0, 0,0,0, 0,16'h0,0,16'h0, 0,8'h00,16'h0},
    '{1,1,8'h10,16'h1111,0, 1,0,8'h10,16'h0,0, 0,0,0, 0,16'h0,1,16'h1111, 0,8'h00,16'h0},
    '{1,0,8'h10,16'h0,0, 1,0,8'h20,16'h0,0, 0,0,0, 1,16'h1111,0,16'h0, 1,8'h10,16'h1111},
    '{1,1,8'h20,16'h2222,0, 1,1,8'h20,16'h3333,0, 0,0,1, 0,16'h0,0,16'h0, 1,8'h10,16'h1111},
    '{1,0,8'h20,16'h0,0, 1,0,8'h20,16'h0,0, 0,0,0, 1,16'h3333,1,16'h3333, 1,8'h10,16'h1111},
    '{1,0,8'h30,16'h0,0, 1,1,8'h30,16'h4444,0, 0,1,0, 0,16'h0,0,16'h0, 1,8'h10,16'h1111},
    '{1,0,8'h30,16'h0,1, 1,1,8'h30,16'h4444,0, 0,0,0, 0,16'h0,0,16'h0, 1,8'h10,16'h1111},
    '{1,1,8'h10,16'h5555,0, 1,0,8'h10,16'h0,0, 0,0,0, 0,16'h0,1,16'h5555, 1,8'h10,16'h1111},
    '{1,0,8'h10,16'h0,0, 1,1,8'h40,16'h6666,0, 1,1,0, 1,16'h5555,0,16'h0, 1,8'h10,16'h1111},
    '{1,0,8'h10,16'h0,0, 1,1,8'h40,16'h6666,1, 1,1,0, 1,16'h5555,0,16'h0, 1,8'h10,16'h1111},
    '{1,0,8'h10,16'h0,0, 1,1,8'h40,16'h6666,0, 0,0,0, 1,16'h5555,0,16'h0, 1,8'h20,16'h3333},
    '{1,1,8'hF0,16'h7777,0, 1,1,8'hF0,16'h8888,1, 1,1,0, 0,16'h0,0,16'h0, 1,8'h20,16'h3333},
    '{0,0,8'h00,16'h0,0, 0,0,8'h00,16'h0,1, 0,0,0, 0,16'h0,0,16'h0, 1,8'h30,16'h4444},
    '{1,1,8'hF0,16'h7777,0, 1,1,8'hF0,16'h8888,0, 0,0,0, 0,16'h0,0,16'h0, 1,8'h10,16'h5555},
    '{1,0,8'hF0,16'h0,0, 1,0,8'h40,16'h0,1, 0,0,0, 1,16'h8888,1,16'h6666, 1,8'h10,16'h5555},
    '{0,0,8'h00,16'h0,0, 0,0,8'h00,16'h0,1, 0,0,0, 0,16'h0,0,16'h0, 1,8'h40,16'h6666},
    '{0,0,8'h00,16'h0,0, 0,0,8'h00,16'h0,1, 0,0,0, 0,16'h0,0,16'h0, 1,8'hF0,16'h7777},
    '{0,0,8'h00,16'h0,0, 0,0,8'h00,16'h0,1, 0,0,0, 0,16'h0,0,16'h0, 1,8'hF0,16'h8888},
    '{0,0,8'h00,16'h0,0, 0,0,8'h00,16'h0,0, 0,0,0, 0,16'h0,0,16'h0, 0,8'h00,16'h0},
    // R9: invalid A store must neither forward nor enter the queue
    '{0,1,8'h50,16'h9999,0, 1,0,8'h50,16'h0,0, 0,0,0, 0,16'h0,0,16'h0, 0,8'h00,16'h0},
    '{1,0,8'h50,16'h0,0, 1,0,8'h50,16'h0,0, 0,0,0, 0,16'h0,0,16'h0, 0,8'h00,16'h0},
    // R10: neighbouring words do not match
    '{1,1,8'h12,16'hAAAA,0, 1,0,8'h13,16'h0,0, 0,0,0, 0,16'h0,0,16'h0, 0,8'h00,16'h0},
    '{1,0,8'h13,16'h0,0, 1,0,8'h12,16'h0,0, 0,0,0, 0,16'h0,1,16'hAAAA, 1,8'h12,16'hAAAA}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    a_vld = 0; a_st = 0; a_addr = '0; a_wdata = '0; a_ld_done = 0;
    b_vld = 0; b_st = 0; b_addr = '0; b_wdata = '0; dr_ack = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1 reset state
    chk(!dr_vld, "R1 dr_vld", 32'(dr_vld), 0);
    chk(!a_stall && !b_stall, "R1 stalls", {30'd0, a_stall, b_stall}, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      a_vld = TBL[i].av; a_st = TBL[i].as; a_addr = TBL[i].aa; a_wdata = TBL[i].ad;
      a_ld_done = TBL[i].adn;
      b_vld = TBL[i].bv; b_st = TBL[i].bs; b_addr = TBL[i].ba; b_wdata = TBL[i].bd;
      dr_ack = TBL[i].ack;
      #2;
      chk(a_stall == TBL[i].ea, $sformatf("R7 a_stall v%0d", i), 32'(a_stall), 32'(TBL[i].ea));
      chk(b_stall == TBL[i].eb, $sformatf("R2 R7 b_stall v%0d", i), 32'(b_stall), 32'(TBL[i].eb));
      chk(a_drop == TBL[i].edrop, $sformatf("R4 R5 a_drop v%0d", i), 32'(a_drop), 32'(TBL[i].edrop));
      chk(a_fwd_hit == TBL[i].eah && (!TBL[i].eah || a_fwd_data == TBL[i].ead),
          $sformatf("R6 R9 R10 a_fwd v%0d", i), {15'd0, a_fwd_hit, a_fwd_data}, {15'd0, TBL[i].eah, TBL[i].ead});
      chk(b_fwd_hit == TBL[i].ebh && (!TBL[i].ebh || b_fwd_data == TBL[i].ebd),
          $sformatf("R3 R6 R9 R10 b_fwd v%0d", i), {15'd0, b_fwd_hit, b_fwd_data}, {15'd0, TBL[i].ebh, TBL[i].ebd});
      chk(dr_vld == TBL[i].edv && (!TBL[i].edv || (dr_addr == TBL[i].eda && dr_data == TBL[i].edd)),
          $sformatf("R5 R8 drain v%0d", i), {7'd0, dr_vld, dr_addr, dr_data}, {7'd0, TBL[i].edv, TBL[i].eda, TBL[i].edd});
    end

    // R1: reset with an entry queued empties the queue
    @(negedge clk);
    idle();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    b_vld = 1; b_addr = 8'h12;
    #2;
    chk(!dr_vld, "R1 queue empty after reset", 32'(dr_vld), 0);
    chk(!b_fwd_hit, "R1 no hit after reset", 32'(b_fwd_hit), 0);

    // R2: long miss keeps B held and its store out of the queue
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      idle();
      a_vld = 1; a_addr = 8'h60;
      b_vld = 1; b_st = 1; b_addr = 8'h60; b_wdata = 16'hBEEF;
      #2;
      chk(b_stall && !a_stall, "R2 hold during miss", {30'd0, a_stall, b_stall}, 32'h1);
      chk(!dr_vld, "R2 store not queued", 32'(dr_vld), 0);
    end
    @(negedge clk);
    a_ld_done = 1;
    #2;
    chk(!b_stall, "R2 release on done", 32'(b_stall), 0);
    @(negedge clk);
    idle();
    #2;
    chk(dr_vld && dr_addr == 8'h60 && dr_data == 16'hBEEF, "R2 store queued after done",
        {7'd0, dr_vld, dr_addr, dr_data}, {7'd0, 1'b1, 8'h60, 16'hBEEF});

    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule